// File: doc/BRIEF.md
# Serial Controller Register Bank

This block is the host-side register file of a PC-compatible serial controller. A host reaches it through an 8-bit WISHBONE slave port with a 3-bit address. The block decodes each transfer into the usual control and status registers of such a controller. It stores the interrupt enable, line control and modem control bytes, the FIFO trigger level and a 16-bit baud divisor, and exports all of them to the rest of the controller.

An address can mean different things depending on the transfer. A read and a write at the same address can reach different registers. While bit 7 of the line control byte (the divisor latch select) is set, addresses 0 and 1 reach the two divisor bytes instead of the data port and the interrupt enable register.

Accesses to the data port and to the FIFO control register have side effects. Each one produces a single-cycle strobe towards the external receive FIFO and transmit FIFO: pop, push or clear. The receive data, interrupt identification, line status and modem status bytes come from outside the block and are only muxed onto the read path.

Top module: `uart_regbank`

## Requirements
- R1: A transfer is accepted only when wb_cyc_i and wb_stb_i are both high and no acknowledge is pending. wb_ack_o rises one cycle after acceptance and stays high for exactly one cycle. If the request is held, acknowledges come every other cycle and never on two cycles in a row.
- R2: After reset the block holds the following values: line control 0x03, interrupt enable 0x00, modem control 0x00, divisor 0x0000 and FIFO trigger 2'b11. All strobes and the acknowledge are low.
- R3: Address 3 reads and writes the line control byte, which is exported on line_ctrl_o. Its bit 7 is the divisor latch select.
- R4: With the latch select clear, address 1 reads and writes the interrupt enable byte, which is exported on int_en_o.
- R5: With the latch select set, address 0 reads and writes divisor bits 7:0 and address 1 reads and writes divisor bits 15:8. In this mode the interrupt enable byte is left untouched. The 16-bit divisor is exported on divisor_o.
- R6: With the latch select clear, a read at address 0 returns rx_data_i and raises rx_pop_o for one cycle, together with the acknowledge. No pop occurs for writes or while the latch select is set.
- R7: With the latch select clear, a write at address 0 raises tx_push_o for one cycle, together with the acknowledge, and tx_data_o carries the written byte. No push occurs while the latch select is set.
- R8: A read at address 2 returns int_id_i. A write at address 2 pulses rx_clr_o from data bit 1 and tx_clr_o from data bit 2, each for one cycle with the acknowledge; these two bits are not stored. The same write stores data bits 7:6 on fifo_trig_o.
- R9: A write at address 4 stores the modem control byte on modem_ctrl_o. A read at address 4 returns 0x00.
- R10: Reads at address 5 and address 6 return line_sts_i and modem_sts_i. Writes to these addresses change no stored state.
- R11: Address 7 reads as 0x00 and ignores writes.
- R12: A strobe without a cycle (or a cycle without a strobe) produces no acknowledge, no strobe and no change of stored state.
- R13: rst_ni is asynchronous. Driving it low restores the R2 values without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wb_cyc_i | input | 1 | Bus cycle in progress |
| wb_stb_i | input | 1 | Transfer strobe |
| wb_we_i | input | 1 | 1 = write, 0 = read |
| wb_adr_i | input | 3 | Register address |
| wb_dat_i | input | 8 | Write data |
| wb_dat_o | output | 8 | Read data, valid with acknowledge |
| wb_ack_o | output | 1 | Transfer acknowledge |
| rx_data_i | input | 8 | Head byte of receive FIFO |
| rx_pop_o | output | 1 | Receive FIFO pop strobe |
| tx_data_o | output | 8 | Byte for transmit FIFO |
| tx_push_o | output | 1 | Transmit FIFO push strobe |
| rx_clr_o | output | 1 | Receive FIFO clear strobe |
| tx_clr_o | output | 1 | Transmit FIFO clear strobe |
| int_id_i | input | 8 | Interrupt identification byte |
| line_sts_i | input | 8 | Line status byte |
| modem_sts_i | input | 8 | Modem status byte |
| int_en_o | output | 8 | Interrupt enable byte |
| line_ctrl_o | output | 8 | Line control byte |
| modem_ctrl_o | output | 8 | Modem control byte |
| fifo_trig_o | output | 2 | Receive FIFO trigger level |
| divisor_o | output | 16 | Baud divisor |

## Verification
The bench switches the latch select on and off around accesses to addresses 0 and 1. A bank decoder with the wrong mapping would show this in two ways: divisor bytes would leak into the interrupt enable byte, or a divisor write would push stray bytes into the transmit FIFO.

The bench holds a request for several cycles. An acknowledge generator without a pending guard would then answer on back-to-back cycles and repeat the pop.

The bench also writes all-ones to the status and unused addresses, and drives a strobe without a cycle. A loose decoder would overwrite stored control bytes in either case.

Finally, the bench pulls reset in mid-cycle. A synchronous reset would keep the old line control value until the next edge.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;
  localparam int unsigned ADR_W = 3;

  typedef enum logic [ADR_W-1:0] {
    A_DATA  = 3'd0,
    A_IEN   = 3'd1,
    A_IDFC  = 3'd2,
    A_LCTL  = 3'd3,
    A_MCTL  = 3'd4,
    A_LSTS  = 3'd5,
    A_MSTS  = 3'd6,
    A_SPARE = 3'd7
  } reg_addr_e;

  localparam int unsigned LATCH_BIT = 7;
  localparam int unsigned RXCLR_BIT = 1;
  localparam int unsigned TXCLR_BIT = 2;
endpackage

// File: rtl/uart_bus_ack.sv
module uart_bus_ack (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cyc_i,
  input  logic stb_i,
  output logic acc_o,
  output logic ack_o
);
  logic ack_q;

  // a pending acknowledge blocks re-acceptance of a held request
  assign acc_o = cyc_i & stb_i & ~ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= acc_o;
  end

  assign ack_o = ack_q;
endmodule

// File: rtl/uart_reg_store.sv
module uart_reg_store
  import uart_regbank_pkg::*;
#(
  parameter int unsigned    DATA_W   = 8,
  parameter int unsigned    NDIV     = 2,
  parameter logic [DATA_W-1:0] LCTL_RST = 8'h03,
  parameter logic [1:0]     TRIG_RST = 2'b11
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     acc_i,
  input  logic                     we_i,
  input  reg_addr_e                adr_i,
  input  logic [DATA_W-1:0]        wdat_i,
  output logic [DATA_W-1:0]        ien_o,
  output logic [DATA_W-1:0]        lctl_o,
  output logic [DATA_W-1:0]        mctl_o,
  output logic [1:0]               trig_o,
  output logic [NDIV*DATA_W-1:0]   div_o,
  output logic                     latch_o
);
  logic wr;
  assign wr      = acc_i & we_i;
  assign latch_o = lctl_o[LATCH_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_o  <= '0;
      lctl_o <= LCTL_RST;
      mctl_o <= '0;
      trig_o <= TRIG_RST;
    end else if (wr) begin
      unique case (adr_i)
        A_IEN:   if (!latch_o) ien_o <= wdat_i;
        A_IDFC:  trig_o <= wdat_i[DATA_W-1 -: 2];
        A_LCTL:  lctl_o <= wdat_i;
        A_MCTL:  mctl_o <= wdat_i;
        default: ;
      endcase
    end
  end

  // one byte lane of the divisor per address, low byte at address 0
  for (genvar g = 0; g < NDIV; g++) begin : g_div
    logic hit;
    assign hit = wr & latch_o & (adr_i == reg_addr_e'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  div_o[g*DATA_W +: DATA_W] <= '0;
      else if (hit) div_o[g*DATA_W +: DATA_W] <= wdat_i;
    end
  end
endmodule

// File: rtl/uart_side_fx.sv
module uart_side_fx
  import uart_regbank_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              we_i,
  input  reg_addr_e         adr_i,
  input  logic [DATA_W-1:0] wdat_i,
  input  logic              latch_i,
  output logic              pop_o,
  output logic              push_o,
  output logic              rxclr_o,
  output logic              txclr_o,
  output logic [DATA_W-1:0] txd_o
);
  logic data_hit, fc_wr;
  assign data_hit = acc_i & ~latch_i & (adr_i == A_DATA);
  assign fc_wr    = acc_i & we_i & (adr_i == A_IDFC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pop_o   <= 1'b0;
      push_o  <= 1'b0;
      rxclr_o <= 1'b0;
      txclr_o <= 1'b0;
      txd_o   <= '0;
    end else begin
      pop_o   <= data_hit & ~we_i;
      push_o  <= data_hit & we_i;
      rxclr_o <= fc_wr & wdat_i[RXCLR_BIT];
      txclr_o <= fc_wr & wdat_i[TXCLR_BIT];
      if (data_hit & we_i) txd_o <= wdat_i;
    end
  end
endmodule

// File: rtl/uart_read_mux.sv
module uart_read_mux
  import uart_regbank_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NDIV   = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   acc_i,
  input  logic                   we_i,
  input  reg_addr_e              adr_i,
  input  logic                   latch_i,
  input  logic [DATA_W-1:0]      rxd_i,
  input  logic [DATA_W-1:0]      iid_i,
  input  logic [DATA_W-1:0]      lsts_i,
  input  logic [DATA_W-1:0]      msts_i,
  input  logic [DATA_W-1:0]      ien_i,
  input  logic [DATA_W-1:0]      lctl_i,
  input  logic [NDIV*DATA_W-1:0] div_i,
  output logic [DATA_W-1:0]      rdat_o
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    unique case (adr_i)
      A_DATA:  sel = latch_i ? div_i[0 +: DATA_W] : rxd_i;
      A_IEN:   sel = latch_i ? div_i[DATA_W +: DATA_W] : ien_i;
      A_IDFC:  sel = iid_i;
      A_LCTL:  sel = lctl_i;
      A_LSTS:  sel = lsts_i;
      A_MSTS:  sel = msts_i;
      default: sel = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdat_o <= '0;
    else         rdat_o <= (acc_i & ~we_i) ? sel : '0;
  end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter logic [7:0]  LCTL_RST = 8'h03,
  parameter logic [1:0]  TRIG_RST = 2'b11
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wb_cyc_i,
  input  logic                wb_stb_i,
  input  logic                wb_we_i,
  input  logic [2:0]          wb_adr_i,
  input  logic [DATA_W-1:0]   wb_dat_i,
  output logic [DATA_W-1:0]   wb_dat_o,
  output logic                wb_ack_o,
  input  logic [DATA_W-1:0]   rx_data_i,
  output logic                rx_pop_o,
  output logic [DATA_W-1:0]   tx_data_o,
  output logic                tx_push_o,
  output logic                rx_clr_o,
  output logic                tx_clr_o,
  input  logic [DATA_W-1:0]   int_id_i,
  input  logic [DATA_W-1:0]   line_sts_i,
  input  logic [DATA_W-1:0]   modem_sts_i,
  output logic [DATA_W-1:0]   int_en_o,
  output logic [DATA_W-1:0]   line_ctrl_o,
  output logic [DATA_W-1:0]   modem_ctrl_o,
  output logic [1:0]          fifo_trig_o,
  output logic [2*DATA_W-1:0] divisor_o
);
  localparam int unsigned NDIV = 2;

  logic      acc, latch;
  reg_addr_e adr;
  assign adr = reg_addr_e'(wb_adr_i);

  uart_bus_ack u_ack (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .cyc_i (wb_cyc_i), .stb_i(wb_stb_i),
    .acc_o (acc), .ack_o(wb_ack_o)
  );

  uart_reg_store #(
    .DATA_W(DATA_W), .NDIV(NDIV), .LCTL_RST(LCTL_RST), .TRIG_RST(TRIG_RST)
  ) u_store (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .acc_i (acc), .we_i(wb_we_i), .adr_i(adr), .wdat_i(wb_dat_i),
    .ien_o (int_en_o), .lctl_o(line_ctrl_o), .mctl_o(modem_ctrl_o),
    .trig_o(fifo_trig_o), .div_o(divisor_o), .latch_o(latch)
  );

  uart_side_fx #(.DATA_W(DATA_W)) u_fx (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .acc_i (acc), .we_i(wb_we_i), .adr_i(adr), .wdat_i(wb_dat_i),
    .latch_i(latch),
    .pop_o (rx_pop_o), .push_o(tx_push_o),
    .rxclr_o(rx_clr_o), .txclr_o(tx_clr_o), .txd_o(tx_data_o)
  );

  uart_read_mux #(.DATA_W(DATA_W), .NDIV(NDIV)) u_rd (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .acc_i (acc), .we_i(wb_we_i), .adr_i(adr), .latch_i(latch),
    .rxd_i (rx_data_i), .iid_i(int_id_i),
    .lsts_i(line_sts_i), .msts_i(modem_sts_i),
    .ien_i (int_en_o), .lctl_i(line_ctrl_o), .div_i(divisor_o),
    .rdat_o(wb_dat_o)
  );
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wb_cyc_i,
  input logic                wb_stb_i,
  input logic                wb_we_i,
  input logic                wb_ack_o,
  input logic                rx_pop_o,
  input logic                tx_push_o,
  input logic                rx_clr_o,
  input logic                tx_clr_o,
  input logic [DATA_W-1:0]   int_en_o,
  input logic [DATA_W-1:0]   line_ctrl_o,
  input logic [DATA_W-1:0]   modem_ctrl_o,
  input logic [2*DATA_W-1:0] divisor_o
);
  AST_ACK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_ack_o |=> !wb_ack_o); // R1
  AST_ACK_HAS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_ack_o |-> $past(wb_cyc_i && wb_stb_i)); // R1
  AST_POP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |-> wb_ack_o && !tx_push_o); // R6
  AST_POP_NO_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |-> !$past(line_ctrl_o[7])); // R6
  AST_PUSH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_push_o |-> wb_ack_o && $past(wb_we_i)); // R7
  AST_PUSH_NO_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_push_o |-> !$past(line_ctrl_o[7])); // R7
  AST_CLR_WITH_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_clr_o || tx_clr_o) |-> wb_ack_o && $past(wb_we_i)); // R8
  AST_IDLE_KEEPS_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wb_cyc_i && wb_stb_i) |-> $stable(line_ctrl_o) && $stable(int_en_o)
      && $stable(modem_ctrl_o) && $stable(divisor_o)); // R12
  AST_READ_KEEPS_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wb_cyc_i && wb_stb_i && !wb_we_i) |-> $stable(line_ctrl_o)
      && $stable(int_en_o) && $stable(divisor_o)); // R3
endmodule

bind uart_regbank uart_regbank_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i),
  .wb_we_i(wb_we_i), .wb_ack_o(wb_ack_o), .rx_pop_o(rx_pop_o),
  .tx_push_o(tx_push_o), .rx_clr_o(rx_clr_o), .tx_clr_o(tx_clr_o),
  .int_en_o(int_en_o), .line_ctrl_o(line_ctrl_o),
  .modem_ctrl_o(modem_ctrl_o), .divisor_o(divisor_o)
);

// File: tb/sim_uart_regbank.sv
`timescale 1ns/1ps
module sim_uart_regbank;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        cyc = 0, stb = 0, we = 0;
  logic [2:0]  adr = '0;
  logic [7:0]  wdat = '0;
  logic [7:0]  rdat, txd, ien, lctl, mctl;
  logic        ack, pop, push, rxc, txc;
  logic [1:0]  trig;
  logic [15:0] div;
  logic [7:0]  rxd = 8'hA5, iid = 8'hC1, lsts = 8'h60, msts = 8'hB0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_regbank u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wb_cyc_i(cyc), .wb_stb_i(stb),
    .wb_we_i(we), .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(rdat),
    .wb_ack_o(ack), .rx_data_i(rxd), .rx_pop_o(pop), .tx_data_o(txd),
    .tx_push_o(push), .rx_clr_o(rxc), .tx_clr_o(txc), .int_id_i(iid),
    .line_sts_i(lsts), .modem_sts_i(msts), .int_en_o(ien),
    .line_ctrl_o(lctl), .modem_ctrl_o(mctl), .fifo_trig_o(trig),
    .divisor_o(div)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one transfer; returns values seen in the acknowledge cycle and one cycle later
  logic [7:0] r_dat, r_txd;
  logic       r_ack, r_pop, r_push, r_rxc, r_txc, r_ack2;
  task automatic xfer(logic w, logic [2:0] a, logic [7:0] d);
    @(negedge clk); cyc = 1; stb = 1; we = w; adr = a; wdat = d;
    @(negedge clk);
    r_ack = ack; r_dat = rdat; r_pop = pop; r_push = push;
    r_rxc = rxc; r_txc = txc; r_txd = txd;
    cyc = 0; stb = 0; we = 0;
    @(negedge clk); r_ack2 = ack;
  endtask

  // {we, adr, wdat, expected read}
  localparam int NV = 22;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 3'd3, 8'h00, 8'h03},  // R2 line control reset
    {1'b0, 3'd1, 8'h00, 8'h00},  // R2 enable reset
    {1'b1, 3'd1, 8'h5A, 8'h00},  // R4
    {1'b0, 3'd1, 8'h00, 8'h5A},  // R4
    {1'b0, 3'd2, 8'h00, 8'hC1},  // R8 identification read
    {1'b0, 3'd5, 8'h00, 8'h60},  // R10
    {1'b0, 3'd6, 8'h00, 8'hB0},  // R10
    {1'b1, 3'd4, 8'h3C, 8'h00},  // R9
    {1'b0, 3'd4, 8'h00, 8'h00},  // R9 write-only reads zero
    {1'b0, 3'd7, 8'h00, 8'h00},  // R11
    {1'b1, 3'd3, 8'h83, 8'h00},  // R3 latch set
    {1'b0, 3'd0, 8'h00, 8'h00},  // R5 divisor low reset
    {1'b1, 3'd0, 8'h34, 8'h00},  // R5 no push
    {1'b1, 3'd1, 8'h12, 8'h00},  // R5
    {1'b0, 3'd0, 8'h00, 8'h34},  // R5 no pop
    {1'b0, 3'd1, 8'h00, 8'h12},  // R5
    {1'b0, 3'd3, 8'h00, 8'h83},  // R3
    {1'b1, 3'd3, 8'h03, 8'h00},  // R3 latch clear
    {1'b0, 3'd1, 8'h00, 8'h5A},  // R5 enable untouched
    {1'b0, 3'd0, 8'h00, 8'hA5},  // R6 receive byte
    {1'b1, 3'd5, 8'hFF, 8'h00},  // R10 ignored
    {1'b0, 3'd3, 8'h00, 8'h03}   // R10 line control intact
  };

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic latch;
    int   acks, prev, dbl;
    latch = 0;
    repeat (3) @(negedge clk);
    // R2 reset state
    chk("R2 lctl", lctl, 8'h03);  chk("R2 ien", ien, 8'h00);
    chk("R2 mctl", mctl, 8'h00);  chk("R2 div", div, 16'h0000);
    chk("R2 trig", trig, 2'b11);
    chk("R2 strobes", {ack, pop, push, rxc, txc}, 5'b0);
    rst_ni = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic       w;
      logic [2:0] a;
      logic [7:0] d, e;
      {w, a, d, e} = VEC[i];
      xfer(w, a, d);
      chk($sformatf("R1 ack row %0d", i), {r_ack, r_ack2}, 2'b10);
      if (!w) chk($sformatf("read row %0d", i), r_dat, e);
      chk($sformatf("R6 pop row %0d", i), r_pop, !w && a == 3'd0 && !latch);
      chk($sformatf("R7 push row %0d", i), r_push, w && a == 3'd0 && !latch);
      if (w && a == 3'd3) latch = d[7];
    end
    chk("R3 lctl export", lctl, 8'h03);
    chk("R4 ien export", ien, 8'h5A);
    chk("R5 div export", div, 16'h1234);
    chk("R9 mctl export", mctl, 8'h3C);

    // R7 push carries data
    xfer(1, 3'd0, 8'h77);
    chk("R7 push", r_push, 1);  chk("R7 data", r_txd, 8'h77);
    chk("R7 no pop", r_pop, 0);

    // R8 clear strobes and trigger
    xfer(1, 3'd2, 8'h86);
    chk("R8 both clears", {r_rxc, r_txc}, 2'b11);
    chk("R8 trig", trig, 2'b10);
    chk("R8 clear one cycle", {rxc, txc}, 2'b00);
    xfer(1, 3'd2, 8'h02);
    chk("R8 rx clear only", {r_rxc, r_txc}, 2'b10);
    chk("R8 trig zero", trig, 2'b00);
    xfer(0, 3'd2, 8'h00);
    chk("R8 id read", r_dat, 8'hC1);

    // R10 / R11 writes ignored
    xfer(1, 3'd6, 8'hFF);
    xfer(1, 3'd7, 8'hFF);
    chk("R10 R11 state", {lctl, ien, mctl, div}, {8'h03, 8'h5A, 8'h3C, 16'h1234});
    chk("R11 no strobes", {r_pop, r_push, r_rxc, r_txc}, 4'b0);

    // R12 strobe without cycle
    @(negedge clk); stb = 1; we = 1; adr = 3'd3; wdat = 8'hFF;
    acks = 0;
    repeat (4) begin @(negedge clk); acks += ack; end
    stb = 0; cyc = 1; adr = 3'd0;
    repeat (2) begin @(negedge clk); acks += ack + push; end
    cyc = 0; we = 0;
    @(negedge clk);
    chk("R12 no ack", acks, 0);
    chk("R12 state", {lctl, ien}, {8'h03, 8'h5A});

    // R1 held request
    @(negedge clk); cyc = 1; stb = 1; we = 0; adr = 3'd1;
    acks = 0; prev = 0; dbl = 0;
    repeat (4) begin
      @(negedge clk);
      if (ack && prev) dbl++;
      acks += ack; prev = ack;
    end
    cyc = 0; stb = 0;
    @(negedge clk);
    chk("R1 held ack count", acks, 2);
    chk("R1 held no back-to-back", dbl, 0);

    // R13 asynchronous reset
    xfer(1, 3'd3, 8'h1B);
    chk("R3 lctl write", lctl, 8'h1B);
    @(negedge clk); #0.5 rst_ni = 0; #0.5;
    chk("R13 lctl", lctl, 8'h03);
    chk("R13 div", div, 16'h0000);
    chk("R13 ien", ien, 8'h00);
    @(negedge clk); rst_ni = 1;
    @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule